// File: doc/BRIEF.md
# Associative Responder Reduction Unit

This unit collects per-element results from an array of N processing elements and turns them into the global answers that a SIMD controller needs to steer associative code. Each element supplies a responder flag produced by an earlier data test, an enable bit saying whether it is currently active, and an 8-bit unsigned data value. In a single combinational pass the unit reports whether any active element responded and which one is chosen as the single responder, both as a one-hot vector and as a binary index. It also forms the global AND and OR of the active flags and the global maximum and minimum of the active data.

A broadcast lane runs alongside the reductions. One scalar operand from the controller is copied to every element's lane. Every result, broadcast lane included, is registered exactly once. Inputs presented before a rising edge therefore appear on the outputs after that edge, whatever the value of N.

Inactive elements are invisible. Each one contributes the identity value of every reduction, so an array with no active elements gives a well-defined, neutral answer.

Top module: `assoc_reduce_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, every result output and every broadcast lane reads zero.
- R2: Every output is registered once. Values sampled from the inputs at a rising edge appear on the outputs just after that edge, and the outputs hold between edges.
- R3: Lane k of `bcast_lanes`, at bits [8k+7:8k], equals the `bcast_val` sampled one edge earlier, for every k.
- R4: `any_hit` is 1 exactly when at least one element has both its `pe_flag` bit and its `pe_en` bit set.
- R5: `pick_onehot` has bit k set only for the lowest-indexed element k that has both flag and enable set. It is all zeros when no such element exists.
- R6: `pick_idx` is the binary index of the element chosen in R5, and `pick_valid` equals `any_hit`. With no active responder, `pick_idx` is 0 and `pick_valid` is 0.
- R7: `and_all` is the AND of the flags of the enabled elements. It is 1 when no element is enabled.
- R8: `or_all` is the OR of the flags of the enabled elements. It is 0 when no element is enabled.
- R9: `max_val` is the largest unsigned data value among the enabled elements, regardless of their flags. It is 0 when none is enabled. Element k's data sits at bits [8k+7:8k] of `pe_data`.
- R10: `min_val` is the smallest unsigned data value among the enabled elements, regardless of their flags. It is 255 when none is enabled.
- R11: The flag and data of an element whose enable is 0 have no effect on any result output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously inside the unit |
| pe_flag | input | N | Responder flag per element, bit k for element k |
| pe_en | input | N | Active enable per element, bit k for element k |
| pe_data | input | 8*N | Data per element, element k at bits [8k+7:8k] |
| bcast_val | input | 8 | Scalar operand to broadcast |
| bcast_lanes | output | 8*N | Registered copy of the operand, one lane per element |
| any_hit | output | 1 | At least one active responder |
| pick_onehot | output | N | One-hot select of the lowest active responder |
| pick_idx | output | clog2(N) | Binary index of the selected responder |
| pick_valid | output | 1 | Selection is valid |
| and_all | output | 1 | AND of the active flags |
| or_all | output | 1 | OR of the active flags |
| max_val | output | 8 | Maximum of the active data |
| min_val | output | 8 | Minimum of the active data |

## Verification
The bench applies patterns with several responders and checks that the lowest one wins. A priority encoder reversed in direction would select the highest responder instead, and a bad index encoder would give an index that disagrees with the one-hot vector. It drives an element that is disabled but carries a set flag and extreme data, and it drives an array with nothing enabled. These catch a design that forgets the enable mask, or that returns 0 rather than 255 as the empty minimum or 0 rather than 1 as the empty AND. Data values of 0 and 255 on enabled elements, at both the first and the last element, expose comparisons that are off by one or signed. A check taken between edges, after the inputs have already changed, catches outputs that are combinational rather than registered.

// File: rtl/assoc_pkg.sv
package assoc_pkg;

  typedef enum logic {
    EXT_MAX = 1'b0,
    EXT_MIN = 1'b1
  } extreme_kind_e;

endpackage

// File: rtl/ar_pick_one.sv
module ar_pick_one #(
  parameter int N     = 16,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     onehot,
  output logic [IDX_W-1:0] idx,
  output logic             found
);

  always_comb begin
    onehot = '0;
    idx    = '0;
    found  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        onehot[i] = 1'b1;
        idx       = IDX_W'(i);
        found     = 1'b1;
      end
    end
  end

endmodule

// File: rtl/ar_bool_reduce.sv
module ar_bool_reduce #(
  parameter int N = 16
) (
  input  logic [N-1:0] flag,
  input  logic [N-1:0] en,
  output logic         all_o,
  output logic         some_o
);

  logic [N-1:0] and_term;
  logic [N-1:0] or_term;

  // Disabled elements contribute the identity: 1 for AND, 0 for OR.
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_term
      assign and_term[g] = flag[g] | ~en[g];
      assign or_term[g]  = flag[g] &  en[g];
    end
  endgenerate

  assign all_o  = &and_term;
  assign some_o = |or_term;

endmodule

// File: rtl/ar_extreme.sv
module ar_extreme
  import assoc_pkg::*;
#(
  parameter int            N    = 16,
  parameter int            W    = 8,
  parameter extreme_kind_e KIND = EXT_MAX
) (
  input  logic [N-1:0]   en,
  input  logic [N*W-1:0] data,
  output logic [W-1:0]   result
);

  localparam logic [W-1:0] IDENT = (KIND == EXT_MAX) ? '0 : '1;

  logic [W-1:0] masked [N];

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_mask
      assign masked[g] = en[g] ? data[g*W +: W] : IDENT;
    end
  endgenerate

  always_comb begin
    result = IDENT;
    for (int i = 0; i < N; i++) begin
      if (KIND == EXT_MAX) begin
        if (masked[i] > result) result = masked[i];
      end else begin
        if (masked[i] < result) result = masked[i];
      end
    end
  end

endmodule

// File: rtl/assoc_reduce_unit.sv
module assoc_reduce_unit
  import assoc_pkg::*;
#(
  parameter int N      = 16,
  parameter int DATA_W = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        pe_flag,
  input  logic [N-1:0]        pe_en,
  input  logic [N*DATA_W-1:0] pe_data,
  input  logic [DATA_W-1:0]   bcast_val,
  output logic [N*DATA_W-1:0] bcast_lanes,
  output logic                any_hit,
  output logic [N-1:0]        pick_onehot,
  output logic [IDX_W-1:0]    pick_idx,
  output logic                pick_valid,
  output logic                and_all,
  output logic                or_all,
  output logic [DATA_W-1:0]   max_val,
  output logic [DATA_W-1:0]   min_val
);

  // Reset synchronizer: asynchronous assertion, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Combinational next-state.
  logic [N-1:0]        req_d;
  logic [N-1:0]        onehot_d;
  logic [IDX_W-1:0]    idx_d;
  logic                found_d;
  logic                all_d;
  logic                some_d;
  logic [DATA_W-1:0]   max_d;
  logic [DATA_W-1:0]   min_d;
  logic [N*DATA_W-1:0] lanes_d;
  logic                upd_en;

  assign req_d  = pe_flag & pe_en;
  assign upd_en = rst_int_n;

  ar_pick_one #(.N(N), .IDX_W(IDX_W)) u_pick (
    .req    (req_d),
    .onehot (onehot_d),
    .idx    (idx_d),
    .found  (found_d)
  );

  ar_bool_reduce #(.N(N)) u_bool (
    .flag   (pe_flag),
    .en     (pe_en),
    .all_o  (all_d),
    .some_o (some_d)
  );

  ar_extreme #(.N(N), .W(DATA_W), .KIND(EXT_MAX)) u_max (
    .en     (pe_en),
    .data   (pe_data),
    .result (max_d)
  );

  ar_extreme #(.N(N), .W(DATA_W), .KIND(EXT_MIN)) u_min (
    .en     (pe_en),
    .data   (pe_data),
    .result (min_d)
  );

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_lane
      assign lanes_d[g*DATA_W +: DATA_W] = bcast_val;
    end
  endgenerate

  // Output registers.
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      bcast_lanes <= '0;
      any_hit     <= 1'b0;
      pick_onehot <= '0;
      pick_idx    <= '0;
      pick_valid  <= 1'b0;
      and_all     <= 1'b0;
      or_all      <= 1'b0;
      max_val     <= '0;
      min_val     <= '0;
    end else if (upd_en) begin
      bcast_lanes <= lanes_d;
      any_hit     <= some_d;
      pick_onehot <= onehot_d;
      pick_idx    <= idx_d;
      pick_valid  <= found_d;
      and_all     <= all_d;
      or_all      <= some_d;
      max_val     <= max_d;
      min_val     <= min_d;
    end
  end

  // Assertions placed beside the registers they guard.
  assert_onehot_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(pick_onehot));

  assert_any_matches_pick_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    any_hit == (pick_onehot != '0));

  assert_idx_points_at_pick_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    pick_valid |-> pick_onehot[pick_idx]);

  assert_empty_idx_zero_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    !pick_valid |-> (pick_idx == '0));

  assert_and_implies_or_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (|pe_en) |=> (!and_all || or_all));

  assert_max_ge_min_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (|pe_en) |=> (max_val >= min_val));

  assert_bcast_lane0_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    rst_sync_q[1] && $past(rst_sync_q[1]) |-> ##0 1'b1 ##1 (bcast_lanes[DATA_W-1:0] == $past(bcast_val)));

endmodule

// File: tb/assoc_reduce_unit_tb.sv
module assoc_reduce_unit_tb;

  localparam int N     = 16;
  localparam int W     = 8;
  localparam int IDX_W = $clog2(N);

  logic              clk;
  logic              rst_n;
  logic [N-1:0]      pe_flag;
  logic [N-1:0]      pe_en;
  logic [N*W-1:0]    pe_data;
  logic [W-1:0]      bcast_val;
  logic [N*W-1:0]    bcast_lanes;
  logic              any_hit;
  logic [N-1:0]      pick_onehot;
  logic [IDX_W-1:0]  pick_idx;
  logic              pick_valid;
  logic              and_all;
  logic              or_all;
  logic [W-1:0]      max_val;
  logic [W-1:0]      min_val;

  int n_checks = 0;
  int n_fail   = 0;

  assoc_reduce_unit #(.N(N), .DATA_W(W)) u_dut (
    .clk, .rst_n, .pe_flag, .pe_en, .pe_data, .bcast_val,
    .bcast_lanes, .any_hit, .pick_onehot, .pick_idx, .pick_valid,
    .and_all, .or_all, .max_val, .min_val
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected results worked out from the requirements.
  task automatic check_expected(input logic [N-1:0] f, input logic [N-1:0] e,
                                input logic [N*W-1:0] d, input logic [W-1:0] bc);
    logic             ex_any = 1'b0;
    logic [N-1:0]     ex_oh  = '0;
    logic [IDX_W-1:0] ex_idx = '0;
    logic             ex_and = 1'b1;
    logic             ex_or  = 1'b0;
    logic [W-1:0]     ex_max = 8'd0;
    logic [W-1:0]     ex_min = 8'd255;
    logic [N*W-1:0]   ex_bc  = {N{bc}};
    for (int k = 0; k < N; k++) begin
      if (e[k]) begin
        if (f[k] && !ex_any) begin
          ex_any = 1'b1;
          ex_oh[k] = 1'b1;
          ex_idx = IDX_W'(k);
        end
        ex_and = ex_and & f[k];
        ex_or  = ex_or | f[k];
        if (d[k*W +: W] > ex_max) ex_max = d[k*W +: W];
        if (d[k*W +: W] < ex_min) ex_min = d[k*W +: W];
      end
    end
    chk("R3 bcast", bcast_lanes, ex_bc);
    chk("R4 any", any_hit, ex_any);
    chk("R5 onehot", pick_onehot, ex_oh);
    chk("R6 idx", pick_idx, ex_idx);
    chk("R6 valid", pick_valid, ex_any);
    chk("R7 and", and_all, ex_and);
    chk("R8 or", or_all, ex_or);
    chk("R9 max", max_val, ex_max);
    chk("R10 min", min_val, ex_min);
  endtask

  task automatic apply_check(input logic [N-1:0] f, input logic [N-1:0] e,
                             input logic [N*W-1:0] d, input logic [W-1:0] bc);
    @(negedge clk);
    pe_flag = f; pe_en = e; pe_data = d; bcast_val = bc;
    @(posedge clk);
    @(negedge clk);
    check_expected(f, e, d, bc);
  endtask

  function automatic logic [N*W-1:0] ramp(input int base, input int step);
    logic [N*W-1:0] r;
    for (int k = 0; k < N; k++) r[k*W +: W] = W'(base + step * k);
    return r;
  endfunction

  task automatic t_reset_r1();
    rst_n = 1'b0;
    pe_flag = '1; pe_en = '1; pe_data = ramp(3, 7); bcast_val = 8'hA5;
    repeat (3) @(negedge clk);
    chk("R1 bcast", bcast_lanes, '0);
    chk("R1 any", any_hit, 1'b0);
    chk("R1 onehot", pick_onehot, '0);
    chk("R1 max", max_val, '0);
    chk("R1 min", min_val, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 first cycle any", any_hit, 1'b0);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_basic_r4();
    apply_check(16'h0010, 16'hFFFF, ramp(10, 5), 8'h3C);
  endtask

  task automatic t_lowest_r5();
    apply_check(16'hA0A4, 16'hFFFB, ramp(200, 3), 8'h01);
  endtask

  task automatic t_all_r7();
    logic [N*W-1:0] d = ramp(1, 1);
    d[0 +: W] = 8'd0;
    d[(N-1)*W +: W] = 8'd255;
    apply_check(16'hFFFF, 16'hFFFF, d, 8'hFF);
  endtask

  task automatic t_last_only_r6();
    apply_check(16'h8000, 16'h8001, ramp(50, 0), 8'h80);
  endtask

  task automatic t_none_enabled_r10();
    apply_check(16'hFFFF, 16'h0000, ramp(9, 11), 8'h00);
  endtask

  task automatic t_disabled_ignored_r11();
    logic [N*W-1:0] d = ramp(60, 1);
    d[0 +: W]        = 8'd255;
    d[15*W +: W]     = 8'd0;
    d[5*W +: W]      = 8'd40;
    d[9*W +: W]      = 8'd100;
    apply_check(16'h0021, 16'h7FFE, d, 8'h5A);
    chk("R11 idx skips disabled", pick_idx, 4'd5);
    chk("R11 max ignores disabled", max_val, 8'd100);
    chk("R11 min ignores disabled", min_val, 8'd40);
  endtask

  task automatic t_no_responder_r9();
    apply_check(16'h0000, 16'h00FF, ramp(30, 9), 8'h11);
    chk("R9 max of enabled", max_val, 8'd93);
  endtask

  task automatic t_latency_r2();
    apply_check(16'h0002, 16'hFFFF, ramp(5, 2), 8'h22);
    @(negedge clk);
    pe_flag = 16'h4000; pe_en = 16'h4000; pe_data = ramp(70, 1); bcast_val = 8'h99;
    #5;
    chk("R2 hold onehot", pick_onehot, 16'h0002);
    chk("R2 hold bcast", bcast_lanes[W-1:0], 8'h22);
    @(posedge clk);
    @(negedge clk);
    chk("R2 update onehot", pick_onehot, 16'h4000);
    chk("R2 update min", min_val, 8'd84);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset_r1();
    t_basic_r4();
    t_lowest_r5();
    t_all_r7();
    t_last_only_r6();
    t_none_enabled_r10();
    t_disabled_ignored_r11();
    t_no_responder_r9();
    t_latency_r2();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule